// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal and vertical sync pulses, an active-video flag and pixel coordinates for a progressive-scan display driven over an analog RGB monitor link. The geometry is not built into the logic. Each segment length lives in a small word-addressed parameter table that other logic or software may rewrite at any time. The generator reads that table through a plain synchronous read port. So one netlist can drive 640x480 at roughly 60 Hz (25 MHz-class pixel clock) or 1920x1080 at 60 Hz (148.5 MHz pixel clock). In each case the pixel clock equals the pixels per frame times the refresh rate.

A loader sweeps the eight timing words of the table without pause into a staging copy. It hands that copy to the counters only where one frame ends and the next begins. A rewrite that lands in the middle of a frame therefore never distorts the frame being scanned. Each axis counts through the same four segments in order: visible region, front porch, sync pulse, back porch. The horizontal axis advances once per pixel clock. The vertical axis advances once per completed line.

Top module: `vga_timing_gen`

## Requirements
- R1: Within each line the horizontal count runs through the visible region (length HA), the front porch (HF), the sync pulse (HS) and the back porch (HB), in that order. `hsync` is asserted exactly for pixel positions HA+HF up to HA+HF+HS-1.
- R2: The vertical count runs through the same four segments in lines (VA, VF, VS, VB). `vsync` is asserted for whole lines VA+VF up to VA+VF+VS-1, and it changes only on a cycle where `active` is low.
- R3: A line lasts HA+HF+HS+HB clocks and a frame lasts VA+VF+VS+VB lines. The horizontal count wraps after its last position and advances the vertical count, which wraps after its own last line.
- R4: `active` is high only when both counts are inside their visible regions. While it is high, `px_x` and `px_y` give the horizontal and vertical position, and `px_x` rises by one each clock along a line, starting at 0.
- R5: While `active` is low, `px_x` and `px_y` are both 0.
- R6: Both syncs are active low. They stay high (deasserted) during reset and until the first frame starts.
- R7: The timing words sit at table word TBL_BASE+{axis,segment}. Axis bit 0 is horizontal and 1 is vertical. Segment codes are 0 visible, 1 front porch, 2 sync, 3 back porch. Each value is at least 1. Read data arrives one clock after `tbl_addr`. The block never addresses a word outside these eight.
- R8: A table change applies from the first frame that begins at least 12 clocks after the change. The frame in progress keeps its old geometry.
- R9: After reset is released, the first frame starts within 12 clocks with `active` high at position (0,0).
- R10: In reset, `active` is 0, `px_x` and `px_y` are 0, and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_addr | output | ADDR_W (5) | Word address into the parameter table |
| tbl_data | input | DATA_W (12) | Table word, valid one clock after its address |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| active | output | 1 | High while the pixel is in the visible area |
| px_x | output | DATA_W (12) | Horizontal pixel position, 0 outside the visible area |
| px_y | output | DATA_W (12) | Vertical line position, 0 outside the visible area |

## Verification
Two events can land in the same clock. The staging copy is taken over by the counters at the very edge where both counts wrap, and that same edge may carry a table word still arriving from the sweep. The bench rewrites the whole table at random geometries right as each frame starts. It then checks every output on every cycle against its own model. The model keeps the old geometry until the frame wrap and only then adopts the new table. A commit that comes early, late or torn shows up as a mismatch in sync position, line length or coordinates.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;
   // Segment order inside one axis; order defines the scan sequence.
   localparam int SEG_N = 4;
   typedef enum logic [1:0] {
      SEG_VIS   = 2'd0,
      SEG_FRONT = 2'd1,
      SEG_PULSE = 2'd2,
      SEG_BACK  = 2'd3
   } seg_e;

   // Axis select bit in the table word index.
   localparam int AXIS_N  = 2;
   localparam int AXIS_H  = 0;
   localparam int AXIS_V  = 1;
   localparam int WORDS_N = SEG_N * AXIS_N;
endpackage

// File: rtl/vga_tg_loader.sv
module vga_tg_loader
   import vga_tg_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 12,
   parameter int TBL_BASE = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   output logic [ADDR_W-1:0]             tbl_addr,
   input  logic [DATA_W-1:0]             tbl_data,
   output logic [SEG_N-1:0][DATA_W-1:0]  h_len,
   output logic [SEG_N-1:0][DATA_W-1:0]  v_len,
   output logic                          run
);
   localparam int IDX_W = $clog2(WORDS_N);

   logic [IDX_W-1:0]                  idx_q;
   logic [IDX_W-1:0]                  idx_d;
   logic                              vld_d;
   logic                              filled_q;
   logic                              run_q;
   logic [WORDS_N-1:0][DATA_W-1:0]    stage_q;
   logic [WORDS_N-1:0][DATA_W-1:0]    live_q;

   assign tbl_addr = ADDR_W'(TBL_BASE) + ADDR_W'(idx_q);
   assign run      = run_q;

   // Sweep the table continuously; data returns one clock after the address.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         idx_d    <= '0;
         vld_d    <= 1'b0;
         filled_q <= 1'b0;
         run_q    <= 1'b0;
         stage_q  <= '0;
         live_q   <= '0;
      end else begin
         idx_q <= (idx_q == IDX_W'(WORDS_N - 1)) ? '0 : idx_q + 1'b1;
         idx_d <= idx_q;
         vld_d <= 1'b1;
         if (vld_d) begin
            stage_q[idx_d] <= tbl_data;
            if (idx_d == IDX_W'(WORDS_N - 1)) filled_q <= 1'b1;
         end
         // Counters take the staged copy only at boot or at a frame seam.
         if (filled_q && (!run_q || commit)) begin
            live_q <= stage_q;
            run_q  <= 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SEG_N; s++) begin : g_split
      assign h_len[s] = live_q[AXIS_H*SEG_N + s];
      assign v_len[s] = live_q[AXIS_V*SEG_N + s];
   end
endmodule

// File: rtl/vga_tg_axis.sv
module vga_tg_axis
   import vga_tg_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int CNT_W      = DATA_W + 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run,
   input  logic                          step,
   input  logic [SEG_N-1:0][DATA_W-1:0]  len,
   output logic [DATA_W-1:0]             coord,
   output logic                          last,
   output logic                          in_vis,
   output logic                          sync_o
);
   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] end_vis;
   logic [CNT_W-1:0] end_front;
   logic [CNT_W-1:0] end_pulse;
   logic [CNT_W-1:0] total;
   logic             in_pulse;

   assign end_vis   = CNT_W'(len[SEG_VIS]);
   assign end_front = end_vis   + CNT_W'(len[SEG_FRONT]);
   assign end_pulse = end_front + CNT_W'(len[SEG_PULSE]);
   assign total     = end_pulse + CNT_W'(len[SEG_BACK]);

   assign last     = (pos_q == total - 1'b1);
   assign in_vis   = run && (pos_q < end_vis);
   assign in_pulse = run && (pos_q >= end_front) && (pos_q < end_pulse);
   assign coord    = in_vis ? pos_q[DATA_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (!run)    pos_q <= '0;
      else if (step)    pos_q <= last ? '0 : pos_q + 1'b1;
   end

   if (ACTIVE_LOW) begin : g_neg
      assign sync_o = ~in_pulse;
   end else begin : g_pos
      assign sync_o = in_pulse;
   end
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
   import vga_tg_pkg::*;
#(
   parameter int ADDR_W          = 5,
   parameter int DATA_W          = 12,
   parameter int TBL_BASE        = 0,
   parameter bit SYNC_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] tbl_addr,
   input  logic [DATA_W-1:0] tbl_data,
   output logic              hsync,
   output logic              vsync,
   output logic              active,
   output logic [DATA_W-1:0] px_x,
   output logic [DATA_W-1:0] px_y
);
   localparam int CNT_W = DATA_W + $clog2(SEG_N);

   if (TBL_BASE < 0 || TBL_BASE + WORDS_N > (1 << ADDR_W)) begin : g_bad_base
      $error("timing table window does not fit the address space");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("table word too narrow");
   end

   logic [SEG_N-1:0][DATA_W-1:0] h_len;
   logic [SEG_N-1:0][DATA_W-1:0] v_len;
   logic                         run;
   logic                         h_last, v_last;
   logic                         h_vis, v_vis;
   logic [DATA_W-1:0]            h_coord, v_coord;
   logic                         frame_seam;

   assign frame_seam = run && h_last && v_last;

   vga_tg_loader #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .TBL_BASE(TBL_BASE)
   ) u_loader (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (frame_seam),
      .tbl_addr(tbl_addr),
      .tbl_data(tbl_data),
      .h_len   (h_len),
      .v_len   (v_len),
      .run     (run)
   );

   vga_tg_axis #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .ACTIVE_LOW(SYNC_ACTIVE_LOW)
   ) u_hax (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (run),
      .len   (h_len),
      .coord (h_coord),
      .last  (h_last),
      .in_vis(h_vis),
      .sync_o(hsync)
   );

   vga_tg_axis #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .ACTIVE_LOW(SYNC_ACTIVE_LOW)
   ) u_vax (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (run && h_last),
      .len   (v_len),
      .coord (v_coord),
      .last  (v_last),
      .in_vis(v_vis),
      .sync_o(vsync)
   );

   assign active = h_vis && v_vis;
   assign px_x   = active ? h_coord : '0;
   assign px_y   = active ? v_coord : '0;
endmodule

// File: rtl/vga_tg_chk.sv
module vga_tg_chk #(
   parameter int ADDR_W          = 5,
   parameter int DATA_W          = 12,
   parameter int TBL_BASE        = 0,
   parameter bit SYNC_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] tbl_addr,
   input logic              hsync,
   input logic              vsync,
   input logic              active,
   input logic [DATA_W-1:0] px_x,
   input logic [DATA_W-1:0] px_y
);
   logic hs_on;
   assign hs_on = SYNC_ACTIVE_LOW ? !hsync : hsync;

   assert_sync_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on |-> !active);

   assert_vsync_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsync) |-> !active);

   assert_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (px_x == '0));

   assert_x_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |->
         (px_x == DATA_W'($past(px_x) + 1'b1)) && (px_y == $past(px_y)));

   assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (px_x == '0) && (px_y == '0));

   assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tbl_addr) >= TBL_BASE) && (int'(tbl_addr) < TBL_BASE + 8));
endmodule

bind vga_timing_gen vga_tg_chk #(
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W),
   .TBL_BASE       (TBL_BASE),
   .SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tbl_addr(tbl_addr),
   .hsync   (hsync),
   .vsync   (vsync),
   .active  (active),
   .px_x    (px_x),
   .px_y    (px_y)
);

// File: tb/sim_vga_timing_gen.sv
`timescale 1ns/1ps
module sim_vga_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  tbl_addr;
   logic [11:0] tbl_data;
   logic        hsync, vsync, active;
   logic [11:0] px_x, px_y;

   logic [11:0] mem [32];
   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   int h, v;
   int lh [4];
   int lv [4];

   always #5 clk = ~clk;

   always_ff @(posedge clk) tbl_data <= mem[tbl_addr];

   vga_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .hsync(hsync), .vsync(vsync), .active(active), .px_x(px_x), .px_y(px_y)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // R7 layout: word {axis,segment}, segment order visible, front, sync, back.
   task automatic set_tbl(input int ha, hf, hs, hb, va, vf, vs, vb);
      mem[0] = 12'(ha); mem[1] = 12'(hf); mem[2] = 12'(hs); mem[3] = 12'(hb);
      mem[4] = 12'(va); mem[5] = 12'(vf); mem[6] = 12'(vs); mem[7] = 12'(vb);
   endtask

   task automatic rand_tbl();
      set_tbl(2 + $urandom % 8, 1 + $urandom % 4, 1 + $urandom % 4, 1 + $urandom % 4,
              2 + $urandom % 6, 1 + $urandom % 3, 1 + $urandom % 3, 1 + $urandom % 3);
   endtask

   task automatic take_live();
      for (int i = 0; i < 4; i++) begin
         lh[i] = int'(mem[i]);
         lv[i] = int'(mem[4 + i]);
      end
   endtask

   task automatic do_reset();
      bit seen;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state, R6 syncs idle high
      chk(active == 1'b0, "R10 active in reset", int'(active), 0);
      chk(px_x == 0 && px_y == 0, "R10 coords in reset", int'(px_x) + int'(px_y), 0);
      chk(hsync && vsync, "R6 syncs idle in reset", int'({hsync, vsync}), 3);
      rst_n = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 14 && !seen; i++) begin
         @(negedge clk);
         if (active) seen = 1'b1;
         else chk(hsync && vsync, "R6 syncs idle before first frame", int'({hsync, vsync}), 3);
      end
      chk(seen, "R9 first frame start", int'(seen), 1);
      chk(px_x == 0 && px_y == 0, "R9 first pixel at origin", int'(px_x) + int'(px_y), 0);
      take_live();
      h = 0;
      v = 0;
   endtask

   task automatic cmp_cycle();
      bit ea, ehs_on, evs_on;
      ea     = (h < lh[0]) && (v < lv[0]);
      ehs_on = (h >= lh[0] + lh[1]) && (h < lh[0] + lh[1] + lh[2]);
      evs_on = (v >= lv[0] + lv[1]) && (v < lv[0] + lv[1] + lv[2]);
      chk(active == ea, "R4 R8 active", int'(active), int'(ea));
      chk(hsync == !ehs_on, "R1 R3 hsync", int'(hsync), int'(!ehs_on));
      chk(vsync == !evs_on, "R2 R3 vsync", int'(vsync), int'(!evs_on));
      chk(int'(px_x) == (ea ? h : 0), "R4 R5 px_x", int'(px_x), ea ? h : 0);
      chk(int'(px_y) == (ea ? v : 0), "R4 R5 px_y", int'(px_y), ea ? v : 0);
      chk(tbl_addr < 5'd8, "R7 table window", int'(tbl_addr), 0);
   endtask

   // Advance the model one pixel; at the frame seam adopt the current table (R8).
   task automatic run_frames(input int n, input bit mutate);
      int frames;
      frames = 0;
      while (frames < n) begin
         cmp_cycle();
         @(negedge clk);
         if (h == lh[0] + lh[1] + lh[2] + lh[3] - 1) begin
            h = 0;
            if (v == lv[0] + lv[1] + lv[2] + lv[3] - 1) begin
               v = 0;
               frames++;
               take_live();
               // R8: rewrite right at frame start; must not affect this frame.
               if (mutate) rand_tbl();
            end else begin
               v++;
            end
         end else begin
            h++;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) mem[i] = 12'hFFF;
      // Directed: tightest legal geometry, every segment one long.
      set_tbl(1, 1, 1, 1, 1, 1, 1, 1);
      do_reset();
      run_frames(3, 1'b0);
      // Random geometries rewritten at each frame start.
      rand_tbl();
      run_frames(1, 1'b0);
      run_frames(40, 1'b1);
      // Directed: reset in mid-frame, restart with current table.
      repeat (7) @(negedge clk);
      set_tbl(4, 2, 3, 1, 3, 1, 2, 1);
      do_reset();
      run_frames(4, 1'b0);
      // Directed: full-HD line timing with a short vertical span.
      set_tbl(1920, 88, 44, 148, 2, 1, 1, 1);
      run_frames(3, 1'b0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog R9: actual 0 expected 1 (run did not complete)");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule